// File: doc/BRIEF.md
# Shared-Pin Reset Sequencer

This block owns one active-low reset line that is used both ways. The block pulls the line low through an open-drain driver, and a momentary switch to ground can also pull it low. The block watches two things. The first is a digital "supply bad" flag from an external voltage comparator. The second is the level it senses back on the line. From these it decides when to pull the line low and when to let the host interface accept inputs again.

While the supply is bad, the line is held low. When the supply comes back, the line stays low for a fixed number of timebase ticks and is then released. A separate gate keeps the host interface disabled for its own count of ticks after the supply returns. A switch press is accepted only after the line has read low for a full debounce window. An accepted press starts the same fixed-length reset pulse.

The block drives the line itself, so it ignores the sensed level while it is pulling the line low. After it releases the line, it must see the line read high again before it starts a new debounce. This prevents the block from retriggering on its own pulse or on a switch that is held down. All delays are counted in ticks of a slow timebase strobe. The asynchronous inputs pass through a two-stage synchronizer before use.

Top module: `reset_pin_ctrl`

## Requirements
- R1: After reset, `pinDriveLow` is 1 and `hostInputsEn` is 0.
- R2: While the synchronized `supplyBadRaw` is 1, `pinDriveLow` is 1 and `hostInputsEn` is 0. A rise on `supplyBadRaw` drives the line low no later than the third clock edge after it.
- R3: Once the synchronized supply flag reads good, `pinDriveLow` stays 1 for exactly `HOLD_TICKS` tick strobes and then goes to 0.
- R4: `hostInputsEn` becomes 1 only after `GATE_TICKS` tick strobes with the supply good. Any supply-bad indication clears it and restarts the count.
- R5: While the block drives the line low, a low sensed level does not lengthen or restart the reset pulse.
- R6: After a release, the sensed line must read high (1) before a press can be detected. A line that stays low after release causes no new pulse.
- R7: If the synchronized sensed level is 0 during `DEBOUNCE_TICKS` consecutive tick strobes, a reset pulse of `HOLD_TICKS` ticks starts.
- R8: A press that ends before the debounce window completes produces no pulse. The next press starts its count from zero.
- R9: A pulse started by the switch leaves `hostInputsEn` unchanged at 1.
- R10: Delays advance only on clock edges where `tickEn` is 1. Without ticks, a pulse or gate in progress holds its state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | One-cycle strobe from the slow timebase |
| supplyBadRaw | input | 1 | Asynchronous supply-bad flag from the comparator, 1 = bad |
| pinSense | input | 1 | Asynchronous sensed level of the shared reset line |
| pinDriveLow | output | 1 | Open-drain enable, 1 = pull line low |
| hostInputsEn | output | 1 | 1 = host interface inputs may be recognized |

## Verification
On every cycle, the assertions check these rules: a supply-bad flag leads to the line being driven, and the gate drops. The line is released only on a tick at the end of the hold. A new pulse starts only from a completed debounce. The block waits in the release state while the line reads low. The gate opens only on a tick. The exact lengths of the hold, debounce and gate windows, and the ordering across whole sequences, are shown only by the bench's reference model. Such sequences include a switch still held after release, a short press, a supply glitch in mid-operation, and a stalled timebase.

// File: rtl/reset_pin_ctrl_pkg.sv
package reset_pin_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_PWR_DOWN = 3'd0,
    ST_HOLD     = 3'd1,
    ST_RELEASE  = 3'd2,
    ST_IDLE     = 3'd3,
    ST_DEBOUNCE = 3'd4
  } seqState_t;

  typedef struct packed {
    logic cntClear;
    logic cntInc;
    logic gateClear;
    logic gateInc;
  } dpStrobe_t;

endpackage

// File: rtl/reset_pin_ctrl_sync.sv
module reset_pin_ctrl_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic asyncIn,
  output logic syncOut
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= RESET_VAL;
        else        chain <= asyncIn;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RESET_VAL}};
        else        chain <= {chain[STAGES-2:0], asyncIn};
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/reset_pin_ctrl_dp.sv
module reset_pin_ctrl_dp
  import reset_pin_ctrl_pkg::*;
#(
  parameter int HOLD_TICKS     = 250,
  parameter int DEBOUNCE_TICKS = 250,
  parameter int GATE_TICKS     = 250,
  parameter int SYNC_STAGES    = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tickEn,
  input  logic      supplyBadRaw,
  input  logic      pinSense,
  input  dpStrobe_t strobe,
  output logic      pfSync,
  output logic      pinSync,
  output logic      cntAtHold,
  output logic      cntAtDeb,
  output logic      gateFull,
  output logic      hostInputsEn
);

  localparam int MAX_T  = (HOLD_TICKS > DEBOUNCE_TICKS) ? HOLD_TICKS : DEBOUNCE_TICKS;
  localparam int CNT_W  = $clog2(MAX_T + 1);
  localparam int GATE_W = $clog2(GATE_TICKS + 1);
  localparam logic [CNT_W-1:0]  HOLD_LAST = CNT_W'(HOLD_TICKS - 1);
  localparam logic [CNT_W-1:0]  DEB_LAST  = CNT_W'(DEBOUNCE_TICKS - 1);
  localparam logic [GATE_W-1:0] GATE_END  = GATE_W'(GATE_TICKS);

  logic [CNT_W-1:0]  delayCnt;
  logic [GATE_W-1:0] gateCnt;

  reset_pin_ctrl_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_pfSync (
    .clk(clk), .rst_n(rst_n), .asyncIn(supplyBadRaw), .syncOut(pfSync)
  );

  reset_pin_ctrl_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_pinSync (
    .clk(clk), .rst_n(rst_n), .asyncIn(pinSense), .syncOut(pinSync)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              delayCnt <= '0;
    else if (strobe.cntClear) delayCnt <= '0;
    else if (strobe.cntInc)   delayCnt <= delayCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                gateCnt <= '0;
    else if (strobe.gateClear) gateCnt <= '0;
    else if (strobe.gateInc)   gateCnt <= gateCnt + 1'b1;
  end

  assign cntAtHold    = (delayCnt == HOLD_LAST);
  assign cntAtDeb     = (delayCnt == DEB_LAST);
  assign gateFull     = (gateCnt == GATE_END);
  assign hostInputsEn = gateFull && !pfSync;

  // R4: a synchronized supply-bad flag closes the gate on the following cycle
  a_r4_gate_restart: assert property (@(posedge clk) disable iff (!rst_n)
    pfSync |=> !hostInputsEn);

  // R10: the gate can only open on a cycle that carried a tick
  a_r10_gate_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hostInputsEn) |-> $past(tickEn));

endmodule

// File: rtl/reset_pin_ctrl_fsm.sv
module reset_pin_ctrl_fsm
  import reset_pin_ctrl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tickEn,
  input  logic      pfSync,
  input  logic      pinSync,
  input  logic      cntAtHold,
  input  logic      cntAtDeb,
  input  logic      gateFull,
  output dpStrobe_t strobe,
  output logic      pinDriveLow
);

  seqState_t state, stateNext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_PWR_DOWN;
    else        state <= stateNext;
  end

  always_comb begin
    stateNext        = state;
    strobe           = '0;
    strobe.gateClear = pfSync;
    strobe.gateInc   = !pfSync && tickEn && !gateFull;
    if (pfSync) begin
      stateNext       = ST_PWR_DOWN;
      strobe.cntClear = 1'b1;
    end else begin
      unique case (state)
        ST_PWR_DOWN: begin
          stateNext       = ST_HOLD;
          strobe.cntClear = 1'b1;
        end
        ST_HOLD: begin
          if (tickEn) begin
            if (cntAtHold) begin
              stateNext       = ST_RELEASE;
              strobe.cntClear = 1'b1;
            end else begin
              strobe.cntInc = 1'b1;
            end
          end
        end
        ST_RELEASE: begin
          if (pinSync) stateNext = ST_IDLE;
        end
        ST_IDLE: begin
          if (!pinSync) begin
            stateNext       = ST_DEBOUNCE;
            strobe.cntClear = 1'b1;
          end
        end
        ST_DEBOUNCE: begin
          if (pinSync) begin
            stateNext = ST_IDLE;
          end else if (tickEn) begin
            if (cntAtDeb) begin
              stateNext       = ST_HOLD;
              strobe.cntClear = 1'b1;
            end else begin
              strobe.cntInc = 1'b1;
            end
          end
        end
        default: stateNext = ST_PWR_DOWN;
      endcase
    end
  end

  assign pinDriveLow = (state == ST_PWR_DOWN) || (state == ST_HOLD);

  // R2: a synchronized supply-bad flag pulls the line low on the next cycle
  a_r2_pf_drives: assert property (@(posedge clk) disable iff (!rst_n)
    pfSync |=> pinDriveLow);

  // R3: the line is released only on a tick that ends the hold window
  a_r3_release_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pinDriveLow) |-> $past(tickEn && cntAtHold));

  // R6: a line still reading low keeps the block waiting after release
  a_r6_wait_high: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RELEASE && !pinSync && !pfSync) |=> (state == ST_RELEASE));

  // R7: a pulse begins only from supply failure or a completed debounce
  a_r7_press_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pinDriveLow) |-> ($past(pfSync) || $past(state == ST_DEBOUNCE && tickEn && cntAtDeb)));

endmodule

// File: rtl/reset_pin_ctrl.sv
module reset_pin_ctrl
  import reset_pin_ctrl_pkg::*;
#(
  parameter int HOLD_TICKS     = 250,
  parameter int DEBOUNCE_TICKS = 250,
  parameter int GATE_TICKS     = 250,
  parameter int SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tickEn,
  input  logic supplyBadRaw,
  input  logic pinSense,
  output logic pinDriveLow,
  output logic hostInputsEn
);

  dpStrobe_t strobe;
  logic pfSync, pinSync, cntAtHold, cntAtDeb, gateFull;

  reset_pin_ctrl_dp #(
    .HOLD_TICKS(HOLD_TICKS), .DEBOUNCE_TICKS(DEBOUNCE_TICKS),
    .GATE_TICKS(GATE_TICKS), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .tickEn(tickEn), .supplyBadRaw(supplyBadRaw),
    .pinSense(pinSense), .strobe(strobe), .pfSync(pfSync), .pinSync(pinSync),
    .cntAtHold(cntAtHold), .cntAtDeb(cntAtDeb), .gateFull(gateFull),
    .hostInputsEn(hostInputsEn)
  );

  reset_pin_ctrl_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .tickEn(tickEn), .pfSync(pfSync), .pinSync(pinSync),
    .cntAtHold(cntAtHold), .cntAtDeb(cntAtDeb), .gateFull(gateFull),
    .strobe(strobe), .pinDriveLow(pinDriveLow)
  );

endmodule

// File: tb/reset_pin_ctrl_tb_top.sv
`timescale 1ns/1ps
module reset_pin_ctrl_tb_top;

  localparam int HOLD = 5;
  localparam int DEB  = 4;
  localparam int GATE = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic pfRaw = 1'b1;
  logic btn = 1'b0;
  logic tickOn = 1'b1;
  logic compareOn = 1'b0;
  logic pinDriveLow, hostInputsEn, pinLevel;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  assign pinLevel = !(pinDriveLow || btn);

  reset_pin_ctrl #(.HOLD_TICKS(HOLD), .DEBOUNCE_TICKS(DEB), .GATE_TICKS(GATE)) dut_i (
    .clk(clk), .rst_n(rst_n), .tickEn(tick), .supplyBadRaw(pfRaw),
    .pinSense(pinLevel), .pinDriveLow(pinDriveLow), .hostInputsEn(hostInputsEn)
  );

  // Behavioural reference: 0 down, 1 hold, 2 wait-high, 3 idle, 4 debounce
  int mSt, mCnt, mGate;
  bit mPf1, mPf2, mPn1, mPn2;

  always @(posedge clk or negedge rst_n) begin
    int nSt, nCnt, nGate;
    bit pinNow;
    if (!rst_n) begin
      mSt = 0; mCnt = 0; mGate = 0;
      mPf1 = 1; mPf2 = 1; mPn1 = 1; mPn2 = 1;
    end else begin
      nSt = mSt; nCnt = mCnt; nGate = mGate;
      pinNow = !((mSt <= 1) || btn);
      if (mPf2) nGate = 0;
      else if (tick && mGate < GATE) nGate = mGate + 1;
      if (mPf2) begin
        nSt = 0; nCnt = 0;
      end else begin
        case (mSt)
          0: begin nSt = 1; nCnt = 0; end
          1: if (tick) begin
               if (mCnt == HOLD - 1) begin nSt = 2; nCnt = 0; end
               else nCnt = mCnt + 1;
             end
          2: if (mPn2) nSt = 3;
          3: if (!mPn2) begin nSt = 4; nCnt = 0; end
          default: if (mPn2) nSt = 3;
                   else if (tick) begin
                     if (mCnt == DEB - 1) begin nSt = 1; nCnt = 0; end
                     else nCnt = mCnt + 1;
                   end
        endcase
      end
      mPf2 = mPf1; mPf1 = pfRaw; mPn2 = mPn1; mPn1 = pinNow;
      mSt = nSt; mCnt = nCnt; mGate = nGate;
    end
  end

  function automatic string stReq(int s);
    case (s)
      0: return "R2";
      1: return "R3/R5";
      2: return "R6";
      3: return "R8";
      default: return "R7";
    endcase
  endfunction

  // Every-cycle comparison against the reference
  always @(negedge clk) begin
    bit expDrive, expHost;
    if (compareOn && !done) begin
      expDrive = (mSt <= 1);
      expHost  = (mGate == GATE) && !mPf2;
      checks++;
      if (pinDriveLow !== expDrive) begin
        fails++;
        $display("FAIL %s pinDriveLow actual=%0b expected=%0b t=%0t", stReq(mSt), pinDriveLow, expDrive, $time);
      end
      checks++;
      if (hostInputsEn !== expHost) begin
        fails++;
        $display("FAIL R4/R9 hostInputsEn actual=%0b expected=%0b t=%0t", hostInputsEn, expHost, $time);
      end
    end
  end

  // Timebase: one tick every third cycle while enabled
  initial begin
    int phase = 0;
    forever begin
      @(negedge clk);
      phase = (phase + 1) % 3;
      tick = tickOn && (phase == 0);
    end
  end

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000 && !done) begin
        fails++;
        $display("FAIL watchdog actual=%0d expected<=20000 cycles", cycles);
        finishRun();
      end
    end
  end

  initial begin
    waitCyc(3);
    rst_n = 1'b1;
    compareOn = 1'b1;
    chk("R1 drive after reset", pinDriveLow, 1'b1);
    chk("R1 host after reset", hostInputsEn, 1'b0);
    waitCyc(10);
    chk("R2 drive while bad", pinDriveLow, 1'b1);
    chk("R2 host while bad", hostInputsEn, 1'b0);
    pfRaw = 1'b0;
    waitCyc(6);
    chk("R3 still holding", pinDriveLow, 1'b1);
    waitCyc(60);
    chk("R3 released", pinDriveLow, 1'b0);
    chk("R4 gate open", hostInputsEn, 1'b1);

    // short press: below debounce window
    btn = 1'b1; waitCyc(6); btn = 1'b0;
    waitCyc(20);
    chk("R8 short press ignored", pinDriveLow, 1'b0);

    // long press with no timebase ticks
    tickOn = 1'b0;
    btn = 1'b1; waitCyc(40);
    chk("R10 no ticks no pulse", pinDriveLow, 1'b0);
    btn = 1'b0; waitCyc(5);
    tickOn = 1'b1;

    // accepted press, switch kept down past the pulse
    btn = 1'b1; waitCyc(22);
    chk("R7 pulse from press", pinDriveLow, 1'b1);
    chk("R9 host unaffected", hostInputsEn, 1'b1);
    waitCyc(40);
    chk("R5 pulse not extended", pinDriveLow, 1'b0);
    waitCyc(30);
    chk("R6 no retrigger while low", pinDriveLow, 1'b0);
    btn = 1'b0; waitCyc(6);
    btn = 1'b1; waitCyc(25);
    chk("R6 rearmed after high", pinDriveLow, 1'b1);
    btn = 1'b0; waitCyc(40);
    chk("R3 press pulse ends", pinDriveLow, 1'b0);

    // supply glitch in mid-operation
    pfRaw = 1'b1; waitCyc(4);
    chk("R2 glitch drives", pinDriveLow, 1'b1);
    chk("R4 glitch closes gate", hostInputsEn, 1'b0);
    pfRaw = 1'b0; waitCyc(12);
    chk("R4 gate restarted", hostInputsEn, 1'b0);
    waitCyc(60);
    chk("R4 gate reopened", hostInputsEn, 1'b1);

    // timebase stalled during the hold
    pfRaw = 1'b1; waitCyc(5);
    tickOn = 1'b0; pfRaw = 1'b0; waitCyc(50);
    chk("R10 hold frozen", pinDriveLow, 1'b1);
    chk("R10 gate frozen", hostInputsEn, 1'b0);
    tickOn = 1'b1; waitCyc(60);
    chk("R10 hold resumes", pinDriveLow, 1'b0);
    chk("R4 gate after resume", hostInputsEn, 1'b1);

    waitCyc(5);
    finishRun();
  end

endmodule